// File: doc/BRIEF.md
# Interleaved Memory Bank Conflict Arbiter

This block sits between two processors and a shared memory built from many independent, interleaved banks. Each processor drives four request ports: three block-transfer ports (slots 0, 1, 2) and one I/O port (slot 3). A request carries a word address, a flag saying the stream steps by an odd increment, and an issue-order tag. Consecutive word addresses fall in consecutive banks. Every bank stays occupied for a fixed number of clocks after it accepts a reference.

In every clock the block drops requests aimed at occupied banks. It then settles contention inside each processor: banks are grouped into four sections, and only one port of a processor may reach a given section per clock. Next it settles contention between the processors for the same bank, using a favoured-processor bit that flips on a fixed period. A port that loses either kind of contention is frozen for the next clock. The requester keeps presenting the same reference until it sees a grant, so each port's references complete in order.

Grants are combinational from the registered state: bank timers, hold flags and the rotation counter. This lets a port retire one reference per clock. Port index is `p*4 + slot`, with `p` the processor number.

Top module: `mem_bank_arbiter`

## Requirements
- R1: The bank of a request is the low log2(NUM_BANKS) bits of its word address, and the row is the remaining upper bits. A granted port reports both on `gnt_bank`/`gnt_row`; a port without a grant reports zero there.
- R2: The section of a bank is its bank number modulo 4. Ports of one processor that address different sections are granted in the same clock when nothing else conflicts.
- R3: A bank granted in clock t is granted to no port in clocks t+1 to t+3. A waiting request to it is granted in clock t+4 at the earliest.
- R4: When ports of different processors request the same free bank in one clock, only the port of the favoured processor is granted. The loser is not granted in the next clock and then waits for the bank timer. With no other traffic it is granted 4 clocks after the winner.
- R5: When several ports of one processor request free banks of the same section in one clock, only the highest-ranked port is granted. Each loser is frozen for the following clock even if its bank is free, so with no other traffic it is granted 2 clocks after the winner.
- R6: Within a processor, a request whose odd-increment flag is 1 outranks a request whose flag is 0.
- R7: Among block-transfer requests with equal odd-increment flags, the smaller issue tag wins; equal tags fall back to the lower slot.
- R8: The I/O port (slot 3) ranks below every block-transfer port of its processor, whatever its flag and tag.
- R9: The favoured processor is processor 0 for the first 4 clocks after reset is released. It then alternates every 4 clocks, so it is processor `(n/4) mod 2` after n clock edges out of reset.
- R10: While reset is high no grant is given. Reset clears all bank timers and hold flags, and a grant is only ever given to a port whose `req_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 8 | Request present, one bit per port |
| req_addr | input | 8*ADDR_W | Word address per port, port i at bits [i*ADDR_W +: ADDR_W] |
| req_odd | input | 8 | 1 = the request's stream uses an odd increment |
| req_tag | input | 8*TAG_W | Issue-order tag per port, smaller is older |
| gnt | output | 8 | Reference accepted this clock |
| gnt_bank | output | 8*BANK_W | Bank of the accepted reference, zero when not granted |
| gnt_row | output | 8*(ADDR_W-BANK_W) | Row (upper address bits) of the accepted reference, zero when not granted |

## Verification
Two functions can land in the same clock: the cross-processor bank contest and the flip of the favoured-processor bit. The bench aligns one same-bank pair to the last clock before a flip and another to the first clock after it, and expects the winner to change between the two. A section contest can also coincide with an occupied bank on a third port. Dense random traffic over a small address range forces both overlaps many times. A behavioural reference model of timers, holds and ranking judges every clock, and a separate check confirms that no bank is granted twice within 4 clocks.

// File: rtl/mbarb_pkg.sv
`timescale 1ns/1ps
package mbarb_pkg;
  localparam int NPROC          = 2;
  localparam int PORTS_PER_PROC = 4;
  localparam int IO_SLOT        = 3;
  localparam int NPORT          = NPROC * PORTS_PER_PROC;
  localparam int SEC_W          = 2;
endpackage

// File: rtl/mbarb_bank_timers.sv
`timescale 1ns/1ps
module mbarb_bank_timers #(
  parameter int NUM_BANKS  = 32,
  parameter int BANK_CYCLE = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] take,
  output logic [NUM_BANKS-1:0] busy
);
  localparam int CNT_W = (BANK_CYCLE > 2) ? $clog2(BANK_CYCLE) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BANK_CYCLE - 1);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (take[gb])       cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy[gb] = (cnt_q != '0);

    // R3
    bank_reuse_chk: assert property (@(posedge clk) disable iff (rst)
      take[gb] |-> !busy[gb]);

    // R3
    bank_occupy_chk: assert property (@(posedge clk) disable iff (rst)
      take[gb] |=> busy[gb]);
  end
endmodule

// File: rtl/mbarb_rotor.sv
`timescale 1ns/1ps
module mbarb_rotor #(
  parameter int ROT_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic favor
);
  localparam int CW = (ROT_PERIOD > 2) ? $clog2(ROT_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROT_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      favor <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      favor <= ~favor;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R9
  favor_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(favor));
endmodule

// File: rtl/mbarb_sect_resolve.sv
`timescale 1ns/1ps
module mbarb_sect_resolve
  import mbarb_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic [PORTS_PER_PROC-1:0]       cand,
  input  logic [PORTS_PER_PROC*SEC_W-1:0] sec,
  input  logic [PORTS_PER_PROC-1:0]       odd,
  input  logic [PORTS_PER_PROC*TAG_W-1:0] tag,
  output logic [PORTS_PER_PROC-1:0]       win
);
  function automatic logic outranks(int a, int b, logic oa, logic ob,
                                    logic [TAG_W-1:0] ta, logic [TAG_W-1:0] tb);
    if (a == IO_SLOT) return 1'b0;
    if (b == IO_SLOT) return 1'b1;
    if (oa != ob)     return oa;
    if (ta != tb)     return ta < tb;
    return a < b;
  endfunction

  always_comb begin
    for (int i = 0; i < PORTS_PER_PROC; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < PORTS_PER_PROC; j++) begin
        if (j != i && cand[j] &&
            sec[j*SEC_W +: SEC_W] == sec[i*SEC_W +: SEC_W] &&
            outranks(j, i, odd[j], odd[i], tag[j*TAG_W +: TAG_W], tag[i*TAG_W +: TAG_W]))
          win[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_bank_arbiter.sv
`timescale 1ns/1ps
module mem_bank_arbiter
  import mbarb_pkg::*;
#(
  parameter int NUM_BANKS  = 32,
  parameter int ADDR_W     = 22,
  parameter int TAG_W      = 6,
  parameter int BANK_CYCLE = 4,
  parameter int ROT_PERIOD = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ROW_W     = ADDR_W - BANK_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        req_vld,
  input  logic [NPORT*ADDR_W-1:0] req_addr,
  input  logic [NPORT-1:0]        req_odd,
  input  logic [NPORT*TAG_W-1:0]  req_tag,
  output logic [NPORT-1:0]        gnt,
  output logic [NPORT*BANK_W-1:0] gnt_bank,
  output logic [NPORT*ROW_W-1:0]  gnt_row
);
  logic [BANK_W-1:0]    bank_of [NPORT];
  logic [ROW_W-1:0]     row_of  [NPORT];
  logic [SEC_W-1:0]     sec_of  [NPORT];
  logic [NUM_BANKS-1:0] busy;
  logic [NUM_BANKS-1:0] take;
  logic [NPORT-1:0]     cand;
  logic [NPORT-1:0]     win;
  logic [NPORT-1:0]     hold_q;
  logic                 favor;

  // address split and first filter: occupied banks and frozen ports
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    assign bank_of[gi] = req_addr[gi*ADDR_W +: BANK_W];
    assign row_of[gi]  = req_addr[gi*ADDR_W+BANK_W +: ROW_W];
    assign sec_of[gi]  = bank_of[gi][SEC_W-1:0];
    assign cand[gi]    = req_vld[gi] & ~hold_q[gi] & ~busy[bank_of[gi]];
  end

  // section contest inside each processor
  for (genvar gp = 0; gp < NPROC; gp++) begin : g_proc
    localparam int LO = gp * PORTS_PER_PROC;
    logic [PORTS_PER_PROC*SEC_W-1:0] sec_pk;
    for (genvar gk = 0; gk < PORTS_PER_PROC; gk++) begin : g_pk
      assign sec_pk[gk*SEC_W +: SEC_W] = sec_of[LO+gk];
    end
    mbarb_sect_resolve #(.TAG_W(TAG_W)) u_res (
      .cand (cand[LO +: PORTS_PER_PROC]),
      .sec  (sec_pk),
      .odd  (req_odd[LO +: PORTS_PER_PROC]),
      .tag  (req_tag[LO*TAG_W +: PORTS_PER_PROC*TAG_W]),
      .win  (win[LO +: PORTS_PER_PROC])
    );
  end

  // bank contest between processors
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      gnt[i] = win[i] & ~rst;
      for (int j = 0; j < NPORT; j++) begin
        if ((j / PORTS_PER_PROC) != (i / PORTS_PER_PROC) && win[j] &&
            bank_of[j] == bank_of[i] && int'(favor) == (j / PORTS_PER_PROC))
          gnt[i] = 1'b0;
      end
    end
  end

  always_comb begin
    take = '0;
    for (int i = 0; i < NPORT; i++)
      if (gnt[i]) take[bank_of[i]] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      gnt_bank[i*BANK_W +: BANK_W] = gnt[i] ? bank_of[i] : '0;
      gnt_row[i*ROW_W +: ROW_W]    = gnt[i] ? row_of[i]  : '0;
    end
  end

  // losers of either contest are frozen for one clock
  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= cand & ~gnt;
  end

  mbarb_bank_timers #(.NUM_BANKS(NUM_BANKS), .BANK_CYCLE(BANK_CYCLE)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .busy (busy)
  );

  mbarb_rotor #(.ROT_PERIOD(ROT_PERIOD)) u_rot (
    .clk   (clk),
    .rst   (rst),
    .favor (favor)
  );

  for (genvar ci = 0; ci < NPORT; ci++) begin : g_chk
    // R10
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      gnt[ci] |-> req_vld[ci]);

    // R5
    held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      hold_q[ci] |-> !gnt[ci]);

    for (genvar cj = ci + 1; cj < NPORT; cj++) begin : g_pair
      // R4
      bank_single_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt[ci] && gnt[cj]) |-> (bank_of[ci] != bank_of[cj]));

      if ((ci / PORTS_PER_PROC) == (cj / PORTS_PER_PROC)) begin : g_same
        // R5
        sect_single_chk: assert property (@(posedge clk) disable iff (rst)
          (gnt[ci] && gnt[cj]) |-> (sec_of[ci] != sec_of[cj]));

        if ((cj % PORTS_PER_PROC) == IO_SLOT) begin : g_io
          // R8
          io_last_chk: assert property (@(posedge clk) disable iff (rst)
            (gnt[cj] && cand[ci]) |-> (sec_of[ci] != sec_of[cj]));
        end
      end
    end
  end
endmodule

// File: tb/test_mem_bank_arbiter.sv
`timescale 1ns/1ps
module test_mem_bank_arbiter;
  localparam int NB = 32;
  localparam int BW = 5;
  localparam int AW = 22;
  localparam int TW = 6;
  localparam int RW = AW - BW;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    req_vld = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP-1:0]    req_odd = '0;
  logic [NP*TW-1:0] req_tag = '0;
  logic [NP-1:0]    gnt;
  logic [NP*BW-1:0] gnt_bank;
  logic [NP*RW-1:0] gnt_row;

  mem_bank_arbiter i_mem_bank_arbiter (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
    .req_odd(req_odd), .req_tag(req_tag), .gnt(gnt), .gnt_bank(gnt_bank),
    .gnt_row(gnt_row)
  );

  always #2.5 clk = ~clk;

  int  q_addr [NP][$];
  bit  q_odd  [NP][$];
  int  q_tag  [NP][$];
  int  ghist  [NP][$];
  int  gbank  [NP][$];
  int  issue  [2];
  int  mbusy  [NB];
  bit  mhold  [NP];
  int  last_g [NB];
  int  nedge, cyc, checks, fails;
  bit  rst_req = 1'b1;
  bit  done = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int p, int a, bit o);
    q_addr[p].push_back(a);
    q_odd[p].push_back(o);
    q_tag[p].push_back(issue[p/4] % 64);
    issue[p/4]++;
  endtask

  task automatic step();
    bit c [NP];
    bit w [NP];
    bit e [NP];
    int b [NP];
    int key [NP];
    int fav;
    logic [NP-1:0] ev;
    @(negedge clk);
    rst = rst_req;
    for (int i = 0; i < NP; i++) begin
      if (q_addr[i].size() > 0) begin
        req_vld[i] = 1'b1;
        req_addr[i*AW +: AW] = AW'(q_addr[i][0]);
        req_odd[i] = q_odd[i][0];
        req_tag[i*TW +: TW] = TW'(q_tag[i][0]);
      end else begin
        req_vld[i] = 1'b0;
        req_addr[i*AW +: AW] = '0;
        req_odd[i] = 1'b0;
        req_tag[i*TW +: TW] = '0;
      end
    end
    #1;
    fav = (nedge / 4) % 2;
    for (int i = 0; i < NP; i++) begin
      b[i] = int'(req_addr[i*AW +: AW]) % NB;
      c[i] = !rst && req_vld[i] && !mhold[i] && mbusy[b[i]] == 0;
      key[i] = ((i % 4 == 3) ? (1 << 20) : 0) + (req_odd[i] ? 0 : (1 << 19)) +
               int'(req_tag[i*TW +: TW]) * 8 + (i % 4);
    end
    for (int i = 0; i < NP; i++) begin
      w[i] = c[i];
      for (int j = 0; j < NP; j++)
        if (j != i && j / 4 == i / 4 && c[j] && (b[j] % 4) == (b[i] % 4) && key[j] < key[i])
          w[i] = 1'b0;
    end
    for (int i = 0; i < NP; i++) begin
      e[i] = w[i];
      for (int j = 0; j < NP; j++)
        if (j / 4 != i / 4 && w[j] && b[j] == b[i] && j / 4 == fav) e[i] = 1'b0;
      ev[i] = e[i];
    end
    if (rst) begin
      check(gnt == '0, "R10", "grant during reset", gnt, 0);
    end else begin
      check(gnt == ev, "R4 R5 R6 R7 R8 R9", "grant vector", gnt, ev);
      for (int i = 0; i < NP; i++) begin
        if (e[i]) begin
          check(int'(gnt_bank[i*BW +: BW]) == b[i], "R1", "granted bank", gnt_bank[i*BW +: BW], b[i]);
          check(int'(gnt_row[i*RW +: RW]) == int'(req_addr[i*AW +: AW]) / NB, "R1", "granted row",
                gnt_row[i*RW +: RW], int'(req_addr[i*AW +: AW]) / NB);
          check(cyc - last_g[b[i]] >= 4, "R3", "bank reuse distance", cyc - last_g[b[i]], 4);
          last_g[b[i]] = cyc;
        end else if (gnt[i] == 1'b0) begin
          check(gnt_bank[i*BW +: BW] == '0 && gnt_row[i*RW +: RW] == '0, "R1",
                "idle port bank/row", gnt_bank[i*BW +: BW], 0);
        end
      end
    end
    @(posedge clk);
    for (int i = 0; i < NP; i++) begin
      if (gnt[i] && q_addr[i].size() > 0) begin
        ghist[i].push_back(cyc);
        gbank[i].push_back(int'(gnt_bank[i*BW +: BW]));
        void'(q_addr[i].pop_front());
        void'(q_odd[i].pop_front());
        void'(q_tag[i].pop_front());
      end
    end
    if (rst) begin
      for (int k = 0; k < NB; k++) mbusy[k] = 0;
      for (int i = 0; i < NP; i++) mhold[i] = 1'b0;
      nedge = 0;
    end else begin
      for (int k = 0; k < NB; k++) if (mbusy[k] > 0) mbusy[k]--;
      for (int i = 0; i < NP; i++) begin
        if (e[i]) mbusy[b[i]] = 3;
        mhold[i] = c[i] && !e[i];
      end
      nedge++;
    end
    cyc++;
  endtask

  function automatic bit queues_empty();
    for (int i = 0; i < NP; i++) if (q_addr[i].size() > 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain();
    for (int n = 0; n < 400 && !queues_empty(); n++) step();
    repeat (5) step();
  endtask

  task automatic clear_hist();
    for (int i = 0; i < NP; i++) begin
      ghist[i].delete();
      gbank[i].delete();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NB; k++) last_g[k] = -100;
    // R10: requests while reset is held
    push(0, 4, 0);
    push(4, 4, 0);
    repeat (3) step();
    for (int i = 0; i < NP; i++) begin
      q_addr[i].delete(); q_odd[i].delete(); q_tag[i].delete();
    end
    clear_hist();
    rst_req = 1'b0;
    repeat (2) step();

    // R1 R3: same bank twice from one port
    push(0, 5, 0);
    push(0, 37, 0);
    drain();
    check(ghist[0].size() == 2, "R3", "grants on port 0", ghist[0].size(), 2);
    if (ghist[0].size() == 2) begin
      check(ghist[0][1] - ghist[0][0] == 4, "R3", "busy spacing", ghist[0][1] - ghist[0][0], 4);
      check(gbank[0][1] == 5, "R1", "bank of address 37", gbank[0][1], 5);
    end
    clear_hist();

    // R5: same section, older tag first, loser frozen one clock
    push(0, 1, 0);
    push(1, 5, 0);
    drain();
    check(ghist[1][0] - ghist[0][0] == 2, "R5", "section loser delay", ghist[1][0] - ghist[0][0], 2);
    clear_hist();

    // R2: different sections granted together
    push(0, 1, 0);
    push(1, 6, 0);
    drain();
    check(ghist[1][0] == ghist[0][0], "R2", "distinct sections same clock", ghist[1][0], ghist[0][0]);
    clear_hist();

    // R6: odd increment beats older even
    push(0, 2, 0);
    push(1, 6, 1);
    drain();
    check(ghist[0][0] - ghist[1][0] == 2, "R6", "odd first", ghist[0][0] - ghist[1][0], 2);
    clear_hist();

    // R7: older tag wins among equal flags
    push(1, 3, 0);
    push(0, 7, 0);
    drain();
    check(ghist[0][0] - ghist[1][0] == 2, "R7", "older tag first", ghist[0][0] - ghist[1][0], 2);
    clear_hist();

    // R8: I/O port loses despite odd flag and older tag
    push(3, 3, 1);
    push(2, 7, 0);
    drain();
    check(ghist[3][0] - ghist[2][0] == 2, "R8", "io port last", ghist[3][0] - ghist[2][0], 2);
    clear_hist();

    // R4 R9: same bank across processors just before the swap
    while (nedge % 8 != 3) step();
    push(0, 9, 0);
    push(4, 9, 0);
    drain();
    check(ghist[4][0] - ghist[0][0] == 4, "R4", "proc 0 favoured, loser delay", ghist[4][0] - ghist[0][0], 4);
    clear_hist();

    // R9: just after the swap processor 1 wins
    while (nedge % 8 != 4) step();
    push(0, 9, 0);
    push(4, 9, 0);
    drain();
    check(ghist[0][0] - ghist[4][0] == 4, "R9", "proc 1 favoured after swap", ghist[0][0] - ghist[4][0], 4);
    clear_hist();

    // random dense traffic, judged by the model every clock
    for (int n = 0; n < 2000; n++) begin
      for (int i = 0; i < NP; i++)
        if (q_addr[i].size() < 3 && $urandom_range(0, 9) < 4)
          push(i, int'($urandom_range(0, 127)), 1'($urandom_range(0, 1)));
      step();
    end
    drain();
    finish_run();
  end
endmodule